// File: doc/BRIEF.md
# SPI-Serviced Window Watchdog

This block supervises a microcontroller. The controller must send a serial frame with its service bit set while a window is open. After the supervised supply becomes good, the block holds its reset line for a programmable delay. It then runs closed and open windows of equal length, one after the other. A service frame that arrives in the open window starts a new closed window at once. A service frame in the closed window counts as a violation, and so does an open window that ends with no service frame. In both cases the error line rises on the next clock. The reset line follows half a window later and is held for the reset delay. After that a fresh closed window begins.

All timing is counted in milliseconds. The millisecond tick comes from a clock prescaler of `TICK_DIV` cycles, which restarts at every phase change, so each phase lasts an exact number of clocks. The serial shifter sits outside the block. It supplies a one-cycle `frame_done` strobe together with the decoded service bit. There is no back-pressure: every strobe is taken in the cycle it is presented, and the block has no ready signal. All other pins are plain levels.

Top module: `spi_window_wdog`

## Requirements
- R1: While `supply_good` is high after a low phase, `rst_out` stays high for a reset delay set by `rst_code` and sampled when the delay starts. The encodings are 2'b00 = 64 ms, 2'b10 = 32 ms, 2'b01 = 16 ms and 2'b11 = 8 ms, with one ms equal to `TICK_DIV` clocks.
- R2: A window lasts a time set by `win_code`: 2'b00 = 128 ms, 2'b10 = 64 ms, 2'b01 = 32 ms, 2'b11 = 16 ms. Closed and open windows use the same table.
- R3: When the power-up delay ends, a closed window starts. When a closed window ends, an open window follows.
- R4: A `frame_done` pulse with `frame_trig` = 1 during an open window starts a new closed window on the next cycle. A `frame_done` pulse with `frame_trig` = 0 has no effect anywhere.
- R5: A service frame during a closed window makes `err_out` and `wd_err` high on the next cycle.
- R6: An open window that runs out with no service frame makes `err_out` high on the next cycle.
- R7: After a violation, `rst_out` rises half a window later, using the length of the window that was violated. It then stays high for the reset delay, and `err_out` stays high from the violation until that delay ends. A full closed window follows.
- R8: Only `en_bits` = 3'b010 disables the watchdog, and every other value enables it. While disabled and with the supply good, `rst_out`, `err_out` and `win_closed` are low, and service frames are ignored.
- R9: When the watchdog is enabled again, a closed window of full length starts on the next cycle.
- R10: `win_closed` is 1 exactly during a closed window.
- R11: `wd_err` is set when a violation occurs and is cleared only by `err_clear`. If a set and a clear fall in the same cycle, the set wins.
- R12: A change of `win_code` or `rst_code` takes effect only when the next phase begins. It never shortens or stretches a phase that is already running.
- R13: `rst_n` low, or `supply_good` low, drives `rst_out` high on the next cycle and drops the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Supervised supply is above its threshold |
| frame_done | input | 1 | One-cycle strobe: a serial frame has completed |
| frame_trig | input | 1 | Service bit of the completed frame |
| en_bits | input | 3 | Enable pattern; 3'b010 disables |
| win_code | input | 2 | Window time code |
| rst_code | input | 2 | Reset delay code |
| err_clear | input | 1 | Clears the sticky error flag |
| rst_out | output | 1 | Reset to the controller, active high |
| err_out | output | 1 | Error line, active high |
| win_closed | output | 1 | 1 in a closed window, 0 otherwise |
| wd_err | output | 1 | Sticky watchdog error flag |

## Verification
Every output is decoded directly from the phase register. A frame strobe, a supply change or an enable change therefore shows at the outputs one clock after the edge that samples it. A phase of L ms lasts exactly L·TICK_DIV clocks, counted from the edge that enters it. The bench drives inputs on falling edges and steps a cycle-level reference model on rising edges. It compares all four outputs at every following falling edge. The directed parts measure the length of each phase by counting falling edges from the first cycle after the edge that starts it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_POR    = 3'd1,
    ST_CLOSED = 3'd2,
    ST_OPEN   = 3'd3,
    ST_FAULT  = 3'd4,
    ST_RESET  = 3'd5,
    ST_IDLE   = 3'd6
  } wd_state_e;

  // Codes halve the longest time; the two code bits are weighted swapped.
  function automatic int unsigned code_to_ms(input logic [1:0] code,
                                             input int unsigned longest);
    return longest >> {code[0], code[1]};
  endfunction

endpackage

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q;

  assign tick = (pc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc_q <= '0;
    else if (restart || tick) pc_q <= '0;
    else                      pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/wd_ms_timer.sv
module wd_ms_timer #(
  parameter int unsigned MS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic [MS_W-1:0] limit_d,
  output logic            expire
);
  logic [MS_W-1:0] count_q;
  logic [MS_W-1:0] limit_q;

  assign expire = tick && (count_q == limit_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '0;
    end else if (start) begin
      count_q <= '0;
      limit_q <= limit_d;
    end else if (tick) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/wd_ctrl.sv
module wd_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned MS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_good,
  input  logic            wd_en,
  input  logic            trig,
  input  logic            expire,
  input  logic            err_clear,
  input  logic [MS_W-1:0] win_len_d,
  input  logic [MS_W-1:0] rst_len_d,
  output logic            start,
  output logic [MS_W-1:0] limit_d,
  output logic            rst_o,
  output logic            err_o,
  output logic            closed_o,
  output logic            flag_o
);
  wd_state_e       state_q, state_d;
  logic [MS_W-1:0] wlen_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:    if (supply_good) state_d = ST_POR;
      ST_POR:    if (expire) state_d = wd_en ? ST_CLOSED : ST_IDLE;
      ST_CLOSED: begin
        if (!wd_en)      state_d = ST_IDLE;
        else if (trig)   state_d = ST_FAULT;
        else if (expire) state_d = ST_OPEN;
      end
      ST_OPEN: begin
        if (!wd_en)      state_d = ST_IDLE;
        else if (trig)   state_d = ST_CLOSED;
        else if (expire) state_d = ST_FAULT;
      end
      ST_FAULT: begin
        if (!wd_en)      state_d = ST_IDLE;
        else if (expire) state_d = ST_RESET;
      end
      ST_RESET:  if (expire) state_d = wd_en ? ST_CLOSED : ST_IDLE;
      ST_IDLE:   if (wd_en) state_d = ST_CLOSED;
      default:   state_d = ST_OFF;
    endcase
    if (!supply_good) state_d = ST_OFF;
  end

  assign start = (state_d != state_q);

  always_comb begin
    case (state_d)
      ST_POR, ST_RESET:   limit_d = rst_len_d;
      ST_CLOSED, ST_OPEN: limit_d = win_len_d;
      ST_FAULT:           limit_d = wlen_q >> 1;
      default:            limit_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      wlen_q  <= '0;
      flag_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start && (state_d == ST_CLOSED || state_d == ST_OPEN))
        wlen_q <= win_len_d;
      if (start && state_d == ST_FAULT) flag_o <= 1'b1;
      else if (err_clear)               flag_o <= 1'b0;
    end
  end

  assign rst_o    = (state_q == ST_OFF) || (state_q == ST_POR) || (state_q == ST_RESET);
  assign err_o    = (state_q == ST_FAULT) || (state_q == ST_RESET);
  assign closed_o = (state_q == ST_CLOSED);

  // R5
  pretrig_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLOSED && supply_good && wd_en && trig) |=> (err_o && flag_o && !closed_o));

  // R4
  open_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN && supply_good && wd_en && trig) |=> (closed_o && !err_o));

  // R8
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && supply_good && (state_q == ST_CLOSED || state_q == ST_OPEN ||
     state_q == ST_FAULT || state_q == ST_IDLE)) |=> (!rst_o && !err_o && !closed_o));

  // R9
  reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && wd_en && supply_good) |=> closed_o);

  // R13
  supply_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> rst_o);

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !err_clear) |=> flag_o);
endmodule

// File: rtl/spi_window_wdog.sv
module spi_window_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 50000,
  parameter int unsigned WIN_MAX_MS = 128,
  parameter int unsigned RST_MAX_MS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_good,
  input  logic       frame_done,
  input  logic       frame_trig,
  input  logic [2:0] en_bits,
  input  logic [1:0] win_code,
  input  logic [1:0] rst_code,
  input  logic       err_clear,
  output logic       rst_out,
  output logic       err_out,
  output logic       win_closed,
  output logic       wd_err
);
  localparam int unsigned LONGEST = (WIN_MAX_MS > RST_MAX_MS) ? WIN_MAX_MS : RST_MAX_MS;
  localparam int unsigned MS_W    = $clog2(LONGEST + 1);

  logic            tick, expire, start, wd_en, trig;
  logic [MS_W-1:0] limit_d, win_len, rst_len;

  assign wd_en   = (en_bits != 3'b010);
  assign trig    = frame_done && frame_trig;
  assign win_len = MS_W'(code_to_ms(win_code, WIN_MAX_MS));
  assign rst_len = MS_W'(code_to_ms(rst_code, RST_MAX_MS));

  wd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(start), .tick(tick)
  );

  wd_ms_timer #(.MS_W(MS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .limit_d(limit_d), .expire(expire)
  );

  wd_ctrl #(.MS_W(MS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .wd_en(wd_en),
    .trig(trig), .expire(expire), .err_clear(err_clear),
    .win_len_d(win_len), .rst_len_d(rst_len), .start(start), .limit_d(limit_d),
    .rst_o(rst_out), .err_o(err_out), .closed_o(win_closed), .flag_o(wd_err)
  );
endmodule

// File: tb/tb_spi_window_wdog.sv
module tb_spi_window_wdog;
  localparam int D = 4;
  localparam int P_OFF = 0, P_POR = 1, P_CL = 2, P_OP = 3, P_FLT = 4, P_RST = 5, P_DIS = 6;

  logic clk = 1'b0;
  logic rst_n, supply_good, frame_done, frame_trig, err_clear;
  logic [2:0] en_bits;
  logic [1:0] win_code, rst_code;
  logic rst_out, err_out, win_closed, wd_err;

  int  n_chk = 0, n_fail = 0;
  bit  chk_on = 0, done = 0;
  int  m_ph = P_OFF, m_left = 0, m_wlen = 128;
  bit  m_err = 0;

  always #10 clk = ~clk;

  spi_window_wdog #(.TICK_DIV(D)) dut (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .frame_done(frame_done),
    .frame_trig(frame_trig), .en_bits(en_bits), .win_code(win_code),
    .rst_code(rst_code), .err_clear(err_clear), .rst_out(rst_out),
    .err_out(err_out), .win_closed(win_closed), .wd_err(wd_err)
  );

  function automatic int win_ms(input logic [1:0] c);
    case (c)
      2'b00: return 128;
      2'b10: return 64;
      2'b01: return 32;
      default: return 16;
    endcase
  endfunction

  function automatic int rst_ms(input logic [1:0] c);
    case (c)
      2'b00: return 64;
      2'b10: return 32;
      2'b01: return 16;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model, stepped on the sampling edge
  always @(posedge clk) begin
    int nph;
    bit trg, en, ex;
    if (!rst_n) begin
      m_ph = P_OFF; m_left = 0; m_err = 0;
    end else begin
      trg = frame_done && frame_trig;
      en  = (en_bits != 3'b010);
      ex  = (m_left == 1);
      if (m_left > 0) m_left--;
      nph = m_ph;
      case (m_ph)
        P_OFF: if (supply_good) nph = P_POR;
        P_POR: if (ex) nph = en ? P_CL : P_DIS;
        P_CL:  if (!en) nph = P_DIS; else if (trg) nph = P_FLT; else if (ex) nph = P_OP;
        P_OP:  if (!en) nph = P_DIS; else if (trg) nph = P_CL; else if (ex) nph = P_FLT;
        P_FLT: if (!en) nph = P_DIS; else if (ex) nph = P_RST;
        P_RST: if (ex) nph = en ? P_CL : P_DIS;
        default: if (en) nph = P_CL;
      endcase
      if (!supply_good) nph = P_OFF;
      if (nph != m_ph) begin
        case (nph)
          P_POR, P_RST: m_left = rst_ms(rst_code) * D;
          P_CL, P_OP: begin m_wlen = win_ms(win_code); m_left = m_wlen * D; end
          P_FLT: m_left = (m_wlen / 2) * D;
          default: m_left = 0;
        endcase
      end
      if (nph == P_FLT && m_ph != P_FLT) m_err = 1;
      else if (err_clear) m_err = 0;
      m_ph = nph;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 R7 R13 rst_out", rst_out, int'(m_ph == P_OFF || m_ph == P_POR || m_ph == P_RST));
      chk("R5 R6 R7 R8 err_out", err_out, int'(m_ph == P_FLT || m_ph == P_RST));
      chk("R3 R10 win_closed", win_closed, int'(m_ph == P_CL));
      chk("R11 wd_err", wd_err, int'(m_err));
    end
  end

  task automatic pulse_trig();
    frame_done = 1; frame_trig = 1;
    @(negedge clk);
    frame_done = 0; frame_trig = 0;
  endtask

  task automatic serve(input logic [1:0] newcode, output int len);
    int n = 0;
    while (!win_closed) @(negedge clk);
    while (win_closed) begin
      n++;
      if (n == 10) win_code = newcode;
      @(negedge clk);
    end
    len = n;
    repeat (3) @(negedge clk);
    pulse_trig();
    chk("R4 valid trigger restarts closed window", win_closed, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst_n = 0; supply_good = 0; frame_done = 0; frame_trig = 0;
    en_bits = 3'b111; win_code = 2'b00; rst_code = 2'b00; err_clear = 0;
    repeat (3) @(negedge clk);
    chk("R13 reset rst_out", rst_out, 1);
    chk("R13 reset err_out", err_out, 0);
    chk("R13 reset win_closed", win_closed, 0);
    chk("R13 reset wd_err", wd_err, 0);
    chk_on = 1;
    rst_n = 1;

    for (int c = 0; c < 4; c++) begin
      supply_good = 0;
      repeat (2) @(negedge clk);
      rst_code = 2'(c);
      supply_good = 1;
      @(negedge clk);
      n = 0;
      while (rst_out && n < 2000) begin n++; @(negedge clk); end
      chk("R1 power-up delay length", n, rst_ms(2'(c)) * D);
      chk("R3 closed window follows delay", win_closed, 1);
    end

    serve(2'b10, n); chk("R12 running window keeps old code", n, win_ms(2'b00) * D);
    serve(2'b01, n); chk("R2 window 64ms", n, win_ms(2'b10) * D);
    serve(2'b11, n); chk("R2 window 32ms", n, win_ms(2'b01) * D);
    serve(2'b00, n); chk("R2 window 16ms", n, win_ms(2'b11) * D);

    win_code = 2'b11;
    frame_done = 1; frame_trig = 0;
    @(negedge clk);
    frame_done = 0;
    chk("R4 frame without service bit ignored", win_closed, 1);
    chk("R4 frame without service bit no error", err_out, 0);
    pulse_trig();
    chk("R5 pretrigger raises err_out", err_out, 1);
    chk("R5 pretrigger sets wd_err", wd_err, 1);
    n = 0;
    while (!rst_out && n < 2000) begin n++; @(negedge clk); end
    chk("R7 reset after half window", n, (win_ms(2'b00) / 2) * D);
    n = 0;
    while (rst_out && n < 2000) begin n++; @(negedge clk); end
    chk("R7 reset pulse length", n, rst_ms(rst_code) * D);
    chk("R7 closed window after reset", win_closed, 1);
    chk("R7 error line released", err_out, 0);
    chk("R11 flag still set", wd_err, 1);
    err_clear = 1;
    @(negedge clk);
    err_clear = 0;
    chk("R11 flag cleared", wd_err, 0);

    while (win_closed) @(negedge clk);
    n = 0;
    while (!err_out && n < 2000) begin n++; @(negedge clk); end
    chk("R6 missed service after open window", n, win_ms(2'b11) * D);
    chk("R6 not closed at error", win_closed, 0);
    while (!win_closed) @(negedge clk);

    repeat (10) @(negedge clk);
    en_bits = 3'b010;
    @(negedge clk);
    chk("R8 disabled closed flag", win_closed, 0);
    chk("R8 disabled reset", rst_out, 0);
    pulse_trig();
    chk("R8 trigger ignored when disabled", err_out, 0);
    repeat (300) @(negedge clk);
    chk("R8 still no reset", rst_out, 0);
    chk("R8 still no error", err_out, 0);
    en_bits = 3'b011;
    @(negedge clk);
    n = 0;
    while (win_closed && n < 2000) begin n++; @(negedge clk); end
    chk("R9 full closed window after enable", n, win_ms(2'b11) * D);

    supply_good = 0;
    @(negedge clk);
    chk("R13 supply loss asserts reset", rst_out, 1);
    chk("R13 supply loss ends window", win_closed, 0);
    supply_good = 1;

    for (int i = 0; i < 60000; i++) begin
      frame_done = 0; frame_trig = 0; err_clear = 0;
      n = int'($urandom_range(0, 9999));
      if (n < 3) supply_good = 0;
      else if (!supply_good && n < 300) supply_good = 1;
      if ($urandom_range(0, 499) == 0)
        en_bits = ($urandom_range(0, 2) == 0) ? 3'b010 : 3'($urandom_range(0, 7));
      if ($urandom_range(0, 299) == 0) win_code = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 299) == 0) rst_code = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) == 0) err_clear = 1;
      if (m_ph == P_OP && $urandom_range(0, 29) == 0) begin
        frame_done = 1; frame_trig = 1;
      end else if (m_ph == P_CL && $urandom_range(0, 1999) == 0) begin
        frame_done = 1; frame_trig = 1;
      end else if ($urandom_range(0, 49) == 0) begin
        frame_done = 1; frame_trig = ($urandom_range(0, 3) == 0);
      end
      @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule